// File: doc/BRIEF.md
# Stacked-Board Command Decoder

This block sits behind a byte link that has already removed its own framing. It receives one byte per valid strobe and turns the byte stream into actions for one board in a stack of boards that all listen to the same link. Every packet opens with a command byte. That byte names a target index, says whether the target is a register or a channel memory, carries a 4-bit board address (or the broadcast address), and says whether the access is a write or a read.

Register commands reach three 8-bit registers: configuration, checksum and frame select. A write sets a register. A read returns its value on a read-data port with a one-cycle valid pulse. Memory write commands carry a 16-bit start address and then any number of 16-bit words, and the block issues one write strobe per word to consecutive addresses. The memories are outside the block.

The configuration register drives several outputs: a self-clearing board reset pulse, a clock doubler enable, a playback enable, a soft trigger that is ORed with the hardware trigger, and the routing of the auxiliary output pin. A packet-boundary input aborts whatever packet is in progress.

Top module: `stack_cmd_decoder`

## Requirements
- R1: The command byte is decoded as follows. Bit 7 is write (1) or read (0). Bits [6:3] are the board address. Bit 2 selects memory (1) or register (0). Bits [1:0] are the index. The register indices are configuration = 0, checksum = 1 and frame select = 2. A register write takes exactly one data byte after the command byte. The new value is visible (for example on `frame_sel`) from the cycle after that data byte is accepted.
- R2: A command is accepted when its board address is 0xF (broadcast) or equals `own_board`. For any other address, the whole packet is discarded: no register changes, no memory strobe and no read pulse.
- R3: A register read command (bit 7 = 0, bit 2 = 0) raises `rd_valid` for exactly one cycle, in the cycle after the command byte. `rd_data` then holds the register's value. Index 3 reads as 0x00. A read changes no register.
- R4: `clk2x_en` follows configuration bit 1 and `play_en` follows configuration bit 2.
- R5: Configuration bit 0 is the board reset. After it is written as 1, `soft_reset` is high for exactly one cycle and then the bit clears itself, while the other configuration bits keep their written values. A later read of the configuration register shows bit 0 as 0.
- R6: `trig_out` is `hw_trig` ORed with configuration bit 3.
- R7: When configuration bit 4 is 1, `aux_out` equals `miso`. When it is 0, `aux_out` is 1 exactly when some channel i (0..2) has both configuration bit 5+i and `chan_aux[i]` set.
- R8: A memory write (bit 7 = 1, bit 2 = 1, index below the memory count) is followed by the start address, low byte first, and then data words, each low byte first. Each word produces a one-cycle `mem_we` with only bit `index` set, in the cycle after its high byte. `mem_addr` then holds the start address plus the word number, modulo 65536, and `mem_wdata` holds the word.
- R9: A memory command with index 3, and any memory read command, produce no `mem_we` and no `rd_valid` for the rest of the packet.
- R10: `pkt_start` abandons the packet in progress, including a half-received word, which is never written. A byte accepted together with `pkt_start` is treated as a command byte.
- R11: After the data byte of a register write, or after a register read command, further bytes are ignored until the next `pkt_start`.
- R12: After reset, all registers are 0, and `rd_valid`, `mem_we`, `soft_reset`, `clk2x_en`, `play_en` and `frame_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_board | input | 4 | Strapped board address |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Byte strobe |
| pkt_start | input | 1 | Packet boundary; byte on this cycle is a command |
| hw_trig | input | 1 | External trigger |
| miso | input | 1 | Serial readback line routed to aux when selected |
| chan_aux | input | 3 | Per-channel aux flags |
| soft_reset | output | 1 | One-cycle board reset pulse |
| clk2x_en | output | 1 | Clock doubler enable |
| play_en | output | 1 | Playback enable |
| trig_out | output | 1 | Combined trigger |
| aux_out | output | 1 | Auxiliary pin drive |
| frame_sel | output | 8 | Frame select register |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Register read value |
| mem_we | output | N_MEM | One-hot memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write word |

## Verification
The assertions assume the link delivers well-formed strobes. They assume `rx_valid` and `pkt_start` are known after reset. They also assume two register writes never arrive in adjacent cycles, which holds because every write needs a command byte and a data byte. The stimulus sends each byte as a one-cycle strobe set up just after the falling edge. It inserts idle gaps between some bytes, and it only changes the trigger, readback and aux inputs between bytes. These rules keep every check tied to a single accepted byte.

// File: rtl/scd_pkg.sv
package scd_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int BRD_W   = 4;
  localparam int AUX_CH  = 3;
  localparam logic [BRD_W-1:0] BRD_ALL = 4'hF;

  localparam logic [1:0] IX_CFG = 2'd0;
  localparam logic [1:0] IX_SUM = 2'd1;
  localparam logic [1:0] IX_FRM = 2'd2;

  typedef struct packed {
    logic             wr;
    logic [BRD_W-1:0] board;
    logic             is_mem;
    logic [1:0]       idx;
  } cmd_t;

  typedef enum logic [2:0] {
    PH_CMD, PH_REG, PH_ALO, PH_AHI, PH_DLO, PH_DHI, PH_SKIP
  } phase_t;

  function automatic logic board_hit(input logic [BRD_W-1:0] b,
                                     input logic [BRD_W-1:0] own);
    return (b == BRD_ALL) || (b == own);
  endfunction

  function automatic logic aux_route(input logic [BYTE_W-1:0] cfg,
                                     input logic miso,
                                     input logic [AUX_CH-1:0] flags);
    logic any;
    any = 1'b0;
    for (int i = 0; i < AUX_CH; i++) any = any | (cfg[5+i] & flags[i]);
    return cfg[4] ? miso : any;
  endfunction

  function automatic logic [WORD_W-1:0] addr_step(input logic [WORD_W-1:0] a);
    return a + 16'd1;
  endfunction

endpackage

// File: rtl/scd_parser.sv
module scd_parser
  import scd_pkg::*;
#(
  parameter int N_MEM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BRD_W-1:0]  own_board,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              pkt_start,
  output logic              reg_wr,
  output logic [1:0]        wr_idx,
  output logic              reg_rd,
  output logic [1:0]        rd_idx,
  output logic              ev_alo,
  output logic              ev_ahi,
  output logic              ev_dlo,
  output logic              ev_dhi,
  output logic [1:0]        mem_sel
);

  phase_t     phase_q, phase_d, eff;
  logic [1:0] widx_q, widx_d;
  logic [1:0] sel_q, sel_d;
  cmd_t       c;
  logic       hit;
  logic       any_ev;

  assign eff = pkt_start ? PH_CMD : phase_q;
  assign c   = cmd_t'(rx_data);
  assign hit = board_hit(c.board, own_board);

  always_comb begin
    phase_d = eff;
    widx_d  = widx_q;
    sel_d   = sel_q;
    reg_wr  = 1'b0;
    reg_rd  = 1'b0;
    ev_alo  = 1'b0;
    ev_ahi  = 1'b0;
    ev_dlo  = 1'b0;
    ev_dhi  = 1'b0;
    if (rx_valid) begin
      unique case (eff)
        PH_CMD: begin
          if (!hit) begin
            phase_d = PH_SKIP;
          end else if (!c.is_mem) begin
            if (c.wr) begin
              phase_d = PH_REG;
              widx_d  = c.idx;
            end else begin
              reg_rd  = 1'b1;
              phase_d = PH_SKIP;
            end
          end else if (c.wr && (int'(c.idx) < N_MEM)) begin
            phase_d = PH_ALO;
            sel_d   = c.idx;
          end else begin
            phase_d = PH_SKIP;
          end
        end
        PH_REG: begin reg_wr = 1'b1; phase_d = PH_SKIP; end
        PH_ALO: begin ev_alo = 1'b1; phase_d = PH_AHI; end
        PH_AHI: begin ev_ahi = 1'b1; phase_d = PH_DLO; end
        PH_DLO: begin ev_dlo = 1'b1; phase_d = PH_DHI; end
        PH_DHI: begin ev_dhi = 1'b1; phase_d = PH_DLO; end
        default: phase_d = PH_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      widx_q  <= '0;
      sel_q   <= '0;
    end else begin
      phase_q <= phase_d;
      widx_q  <= widx_d;
      sel_q   <= sel_d;
    end
  end

  assign wr_idx  = widx_q;
  assign rd_idx  = c.idx;
  assign mem_sel = sel_q;
  assign any_ev  = reg_wr | reg_rd | ev_alo | ev_ahi | ev_dlo | ev_dhi;

  // R11: a finished packet is silent until the next boundary
  a_r11_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP && !pkt_start) |-> !any_ev);

  // R2: a foreign command never starts any action
  a_r2_foreign_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && eff == PH_CMD && !hit) |=> (phase_q == PH_SKIP));

  // R10: a bare boundary returns the parser to command phase
  a_r10_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !rx_valid) |=> (phase_q == PH_CMD));

  // R9: memory selection only ever names an existing memory
  a_r9_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dhi |-> (int'(sel_q) < N_MEM));

endmodule

// File: rtl/scd_regfile.sv
module scd_regfile
  import scd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        wr_idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              reg_rd,
  input  logic [1:0]        rd_idx,
  input  logic              hw_trig,
  input  logic              miso,
  input  logic [AUX_CH-1:0] chan_aux,
  output logic              soft_reset,
  output logic              clk2x_en,
  output logic              play_en,
  output logic              trig_out,
  output logic              aux_out,
  output logic [BYTE_W-1:0] frame_sel,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);

  logic [BYTE_W-1:0] cfg_q, sum_q, frm_q;
  logic [BYTE_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sum_q <= '0;
      frm_q <= '0;
    end else begin
      if (reg_wr && wr_idx == IX_CFG) cfg_q <= wdata;
      else                            cfg_q <= {cfg_q[BYTE_W-1:1], 1'b0};
      if (reg_wr && wr_idx == IX_SUM) sum_q <= wdata;
      if (reg_wr && wr_idx == IX_FRM) frm_q <= wdata;
    end
  end

  always_comb begin
    unique case (rd_idx)
      IX_CFG:  rd_mux = cfg_q;
      IX_SUM:  rd_mux = sum_q;
      IX_FRM:  rd_mux = frm_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_mux;
    end
  end

  assign soft_reset = cfg_q[0];
  assign clk2x_en   = cfg_q[1];
  assign play_en    = cfg_q[2];
  assign trig_out   = hw_trig | cfg_q[3];
  assign aux_out    = aux_route(cfg_q, miso, chan_aux);
  assign frame_sel  = frm_q;

  // R5: the reset bit lasts one cycle
  a_r5_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !soft_reset);

  // R3: a read pulse always answers a read request
  a_r3_rd_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(reg_rd));

  // R3: reads leave the frame register untouched
  a_r3_rd_no_side: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> $stable(frame_sel));

endmodule

// File: rtl/scd_memwr.sv
module scd_memwr
  import scd_pkg::*;
#(
  parameter int N_MEM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              ev_alo,
  input  logic              ev_ahi,
  input  logic              ev_dlo,
  input  logic              ev_dhi,
  input  logic [1:0]        mem_sel,
  output logic [N_MEM-1:0]  mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);

  logic [WORD_W-1:0] ptr_q;
  logic [BYTE_W-1:0] lo_q;
  logic [N_MEM-1:0]  sel_hot;

  for (genvar i = 0; i < N_MEM; i++) begin : g_hot
    assign sel_hot[i] = (mem_sel == 2'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      lo_q      <= '0;
      mem_we    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= '0;
      if (ev_alo) ptr_q[BYTE_W-1:0]      <= byte_in;
      if (ev_ahi) ptr_q[WORD_W-1:BYTE_W] <= byte_in;
      if (ev_dlo) lo_q                   <= byte_in;
      if (ev_dhi) begin
        mem_we    <= sel_hot;
        mem_addr  <= ptr_q;
        mem_wdata <= {byte_in, lo_q};
        ptr_q     <= addr_step(ptr_q);
      end
    end
  end

  // R8: strobes are one-hot
  a_r8_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_we));

  // R8: a strobe follows a completed word
  a_r8_we_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0) |-> $past(ev_dhi));

  // R8: back-to-back words of one burst land on adjacent addresses
  a_r8_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dhi && !ev_alo && !ev_ahi) |=> (ptr_q == addr_step(mem_addr)));

endmodule

// File: rtl/stack_cmd_decoder.sv
module stack_cmd_decoder
  import scd_pkg::*;
#(
  parameter int N_MEM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        own_board,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              pkt_start,
  input  logic              hw_trig,
  input  logic              miso,
  input  logic [2:0]        chan_aux,
  output logic              soft_reset,
  output logic              clk2x_en,
  output logic              play_en,
  output logic              trig_out,
  output logic              aux_out,
  output logic [7:0]        frame_sel,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [N_MEM-1:0]  mem_we,
  output logic [15:0]       mem_addr,
  output logic [15:0]       mem_wdata
);

  logic       reg_wr, reg_rd;
  logic [1:0] wr_idx, rd_idx, mem_sel;
  logic       ev_alo, ev_ahi, ev_dlo, ev_dhi;

  scd_parser #(.N_MEM(N_MEM)) u_parse (
    .clk(clk), .rst_n(rst_n), .own_board(own_board),
    .rx_data(rx_data), .rx_valid(rx_valid), .pkt_start(pkt_start),
    .reg_wr(reg_wr), .wr_idx(wr_idx), .reg_rd(reg_rd), .rd_idx(rd_idx),
    .ev_alo(ev_alo), .ev_ahi(ev_ahi), .ev_dlo(ev_dlo), .ev_dhi(ev_dhi),
    .mem_sel(mem_sel)
  );

  scd_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .wr_idx(wr_idx), .wdata(rx_data),
    .reg_rd(reg_rd), .rd_idx(rd_idx),
    .hw_trig(hw_trig), .miso(miso), .chan_aux(chan_aux),
    .soft_reset(soft_reset), .clk2x_en(clk2x_en), .play_en(play_en),
    .trig_out(trig_out), .aux_out(aux_out), .frame_sel(frame_sel),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  scd_memwr #(.N_MEM(N_MEM)) u_mem (
    .clk(clk), .rst_n(rst_n), .byte_in(rx_data),
    .ev_alo(ev_alo), .ev_ahi(ev_ahi), .ev_dlo(ev_dlo), .ev_dhi(ev_dhi),
    .mem_sel(mem_sel),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R9: register traffic and memory traffic never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_we == '0));

endmodule

// File: tb/stack_cmd_decoder_test.sv
module stack_cmd_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] OWN = 4'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, pkt_start = 1'b0, hw_trig = 1'b0, miso = 1'b0;
  logic [2:0] chan_aux = '0;
  logic soft_reset, clk2x_en, play_en, trig_out, aux_out, rd_valid;
  logic [7:0] frame_sel, rd_data;
  logic [2:0] mem_we;
  logic [15:0] mem_addr, mem_wdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .own_board(OWN), .rx_data(rx_data),
    .rx_valid(rx_valid), .pkt_start(pkt_start), .hw_trig(hw_trig),
    .miso(miso), .chan_aux(chan_aux), .soft_reset(soft_reset),
    .clk2x_en(clk2x_en), .play_en(play_en), .trig_out(trig_out),
    .aux_out(aux_out), .frame_sel(frame_sel), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 command, 1 reg data, 2/3 address bytes,
  // 4/5 word bytes, 6 ignore rest
  int ph = 0;
  logic [7:0] m_cfg = 0, m_sum = 0, m_frm = 0, m_lo = 0, m_rdd = 0;
  logic [1:0] m_widx = 0, m_sel = 0;
  logic m_rdv = 0;
  logic [2:0] m_we = 0;
  logic [15:0] m_ptr = 0, m_addr = 0, m_wd = 0;

  function automatic logic [7:0] pick(input logic [1:0] i, input logic [7:0] a,
                                      input logic [7:0] b, input logic [7:0] f);
    if (i == 0) return a;
    if (i == 1) return b;
    if (i == 2) return f;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_cfg = 0; m_sum = 0; m_frm = 0; m_rdv = 0; m_we = 0;
      m_ptr = 0; m_addr = 0; m_wd = 0; m_rdd = 0;
    end else begin
      int p;
      logic [7:0] old_cfg;
      p = pkt_start ? 0 : ph;
      old_cfg = m_cfg;
      m_cfg[0] = 1'b0;
      m_rdv = 0;
      m_we = 0;
      ph = p;
      if (rx_valid) begin
        case (p)
          0: begin
            if (rx_data[6:3] != 4'hF && rx_data[6:3] != OWN) ph = 6;
            else if (!rx_data[2]) begin
              if (rx_data[7]) begin ph = 1; m_widx = rx_data[1:0]; end
              else begin
                m_rdv = 1; ph = 6;
                m_rdd = pick(rx_data[1:0], old_cfg, m_sum, m_frm);
              end
            end else if (rx_data[7] && rx_data[1:0] != 2'd3) begin
              ph = 2; m_sel = rx_data[1:0];
            end else ph = 6;
          end
          1: begin
            if (m_widx == 0) m_cfg = rx_data;
            else if (m_widx == 1) m_sum = rx_data;
            else if (m_widx == 2) m_frm = rx_data;
            ph = 6;
          end
          2: begin m_ptr[7:0] = rx_data; ph = 3; end
          3: begin m_ptr[15:8] = rx_data; ph = 4; end
          4: begin m_lo = rx_data; ph = 5; end
          5: begin
            m_we = 3'b001 << m_sel; m_addr = m_ptr; m_wd = {rx_data, m_lo};
            m_ptr = m_ptr + 16'd1; ph = 4;
          end
          default: ph = 6;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk("R3 rd_data", rd_data, m_rdd);
      chk("R8 mem_we", mem_we, m_we);
      if (m_we != 0) begin
        chk("R8 mem_addr", mem_addr, m_addr);
        chk("R8 mem_wdata", mem_wdata, m_wd);
      end
      chk("R1 frame_sel", frame_sel, m_frm);
      chk("R5 soft_reset", soft_reset, m_cfg[0]);
      chk("R4 clk2x_en", clk2x_en, m_cfg[1]);
      chk("R4 play_en", play_en, m_cfg[2]);
      chk("R6 trig_out", trig_out, hw_trig | m_cfg[3]);
      chk("R7 aux_out", aux_out,
          m_cfg[4] ? miso : ((m_cfg[7:5] & chan_aux) != 0));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic send(input logic [7:0] b, input bit first);
    rx_data = b; rx_valid = 1'b1; pkt_start = first;
    @(negedge clk); #1;
    rx_valid = 1'b0; pkt_start = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d);
    send(cmd, 1); send(d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R12 reset state
    chk("R12 frame_sel", frame_sel, 0);
    chk("R12 rd_valid", rd_valid, 0);
    chk("R12 mem_we", mem_we, 0);
    chk("R12 cfg outs", {soft_reset, clk2x_en, play_en}, 0);
    rst_n = 1'b1;
    tick();

    // R1 frame write (cmd 0xAA = write, board 5, reg, idx 2)
    wr_reg(8'hAA, 8'h3C);
    chk("R1 frame write", frame_sel, 8'h3C);
    // R3 checksum write then read
    wr_reg(8'hA9, 8'h5A); tick();
    send(8'h29, 1);
    chk("R3 read valid", rd_valid, 1);
    chk("R3 read sum", rd_data, 8'h5A);
    tick();
    chk("R3 pulse one cycle", rd_valid, 0);
    send(8'h2B, 1);
    chk("R3 index3 reads zero", rd_data, 8'h00);

    // R4/R5 config with reset bit
    wr_reg(8'hA8, 8'h07);
    chk("R5 reset high", soft_reset, 1);
    chk("R4 clk2x", clk2x_en, 1);
    chk("R4 play", play_en, 1);
    tick();
    chk("R5 reset cleared", soft_reset, 0);
    chk("R5 others kept", {clk2x_en, play_en}, 2'b11);
    send(8'h28, 1);
    chk("R5 read back cfg", rd_data, 8'h06);

    // R2 broadcast and foreign
    wr_reg(8'hFA, 8'h11);
    chk("R2 broadcast write", frame_sel, 8'h11);
    wr_reg(8'h9A, 8'h99);
    chk("R2 foreign write ignored", frame_sel, 8'h11);
    send(8'h1A, 1);
    chk("R2 foreign read no pulse", rd_valid, 0);
    send(8'h9D, 1); send(8'h00, 0); send(8'h00, 0); send(8'h11, 0); send(8'h22, 0);
    chk("R2 foreign mem no write", mem_we, 0);

    // R6 trigger
    wr_reg(8'hA8, 8'h08);
    chk("R6 soft trigger", trig_out, 1);
    wr_reg(8'hA8, 8'h00);
    hw_trig = 1; #1;
    chk("R6 hw trigger", trig_out, 1);
    hw_trig = 0; #1;
    chk("R6 no trigger", trig_out, 0);

    // R7 aux routing
    wr_reg(8'hA8, 8'h10);
    miso = 1; #1; chk("R7 miso high", aux_out, 1);
    miso = 0; #1; chk("R7 miso low", aux_out, 0);
    wr_reg(8'hA8, 8'hA0);
    chan_aux = 3'b010; #1; chk("R7 masked channel", aux_out, 0);
    chan_aux = 3'b100; #1; chk("R7 channel 2", aux_out, 1);
    chan_aux = 3'b001; #1; chk("R7 channel 0", aux_out, 1);
    wr_reg(8'hA8, 8'h00);
    chan_aux = 3'b111; #1; chk("R7 empty mask", aux_out, 0);

    // R8 memory burst with wrap (cmd 0xAD = write, board 5, mem, idx 1)
    send(8'hAD, 1); send(8'hFE, 0); send(8'hFF, 0); send(8'h34, 0); send(8'h12, 0);
    chk("R8 we word0", mem_we, 3'b010);
    chk("R8 addr word0", mem_addr, 16'hFFFE);
    chk("R8 data word0", mem_wdata, 16'h1234);
    tick(); tick();
    send(8'hCD, 0); tick(); send(8'hAB, 0);
    chk("R8 addr word1", mem_addr, 16'hFFFF);
    chk("R8 data word1", mem_wdata, 16'hABCD);
    send(8'h0F, 0); send(8'hF0, 0);
    chk("R8 addr wraps", mem_addr, 16'h0000);
    send(8'hAC, 1); send(8'h10, 0); send(8'h00, 0); send(8'h01, 0); send(8'h02, 0);
    chk("R8 memory 0 select", mem_we, 3'b001);

    // R9 index 3 and memory read
    send(8'hAF, 1); send(8'h00, 0); send(8'h00, 0); send(8'h11, 0); send(8'h22, 0);
    chk("R9 index3 no write", mem_we, 0);
    send(8'h2D, 1);
    chk("R9 mem read no pulse", rd_valid, 0);
    send(8'h00, 0); send(8'h00, 0);
    chk("R9 mem read no write", mem_we, 0);

    // R10 abort mid word; new command on boundary
    send(8'hAE, 1); send(8'h00, 0); send(8'h01, 0); send(8'h55, 0);
    send(8'h2A, 1);
    chk("R10 new cmd read", rd_valid, 1);
    chk("R10 half word dropped", mem_we, 0);
    send(8'h66, 0);
    chk("R10 no late write", mem_we, 0);
    send(8'hAA, 1); pkt_start = 1; tick(); pkt_start = 0;
    send(8'h77, 0);
    chk("R10 aborted reg write", frame_sel, 8'h11);

    // R11 trailing bytes ignored
    wr_reg(8'hAA, 8'h22);
    send(8'hAA, 0); send(8'h44, 0);
    chk("R11 trailing ignored", frame_sel, 8'h22);
    send(8'h2A, 1); send(8'h2A, 0);
    chk("R11 after read ignored", rd_valid, 0);

    repeat (3) tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule